// File: doc/BRIEF.md
# Addressed Serial Port Expander Slave

This block is the slave side of an 8-bit port expander that a host controls over four wires: a frame strobe, a serial clock, serial data in and serial data out. While the strobe is low the host clocks in a 16-bit frame, most significant bit first. The first byte holds a device address and a command, and the second byte holds data. The block compares the address with its strap inputs. Only a matching frame gets an answer on the data-out line and only a matching frame is acted on.

A mode input selects one of two framings. In normal framing the address is four bits wide and the block answers with an acknowledge level followed by a data byte. In echo framing the address is three bits wide and the block returns the address and the low two command bits it has just received, followed by the data byte. The data byte is either the port pin levels captured when the frame started or, on a read-back command, the output register. Writing the output register and presenting it on the port are separate commands, and a flag gates whether the port is driven at all. Each port bit is modelled as an open-drain driver, as an output level plus an enable.

All logic runs on one system clock that must be at least eight times the serial clock. The strobe, the serial clock and the serial data pass through synchronizers, and each data bit is taken as the majority of three successive samples.

Top module: `ioexp_slave`

## Requirements
- R1: A falling edge on `ser_en` captures `pin_in`. Every command other than read-back returns that captured byte, MSB first, on the 8 data-phase bits.
- R2: Each data-in bit is latched at a rising edge of `ser_clk` as the majority of three successive synchronized samples. A one-sample glitch does not change the received bit.
- R3: In normal framing the first 4 frame bits are compared with `addr_strap[3:0]`. In echo framing the first 3 frame bits are compared with `addr_strap[2:0]`. On a mismatch `ser_do_oe` stays low for the whole frame and no command runs.
- R4: `ser_do_oe` stays low until the address bits are complete. After a match, `ser_do` and `ser_do_oe` change only after a falling edge of `ser_clk`.
- R5: In normal framing (`echo_mode`=0) the frame is address[15:12], command[11:9], a spare bit [8] and data[7:0]. The host sees level 0 (acknowledge) before rising edges 5 to 8, then data bits 7 down to 0 before rising edges 9 to 16.
- R6: In echo framing (`echo_mode`=1) the frame is address[15:13], command[12:10], two spare bits [9:8] and data[7:0]. Before rising edges 4 to 8 the host sees frame bits 15, 14, 13, 11 and 10, then data bits 7 down to 0 before rising edges 9 to 16.
- R7: A command runs at the rising edge of `ser_en` only if exactly 16 `ser_clk` rising edges were received. `ser_do_oe` drops at that rising edge of `ser_en`.
- R8: Command 000 loads the data byte into the output register and does not change the port. Command 001 copies the output register to the port latch.
- R9: Command 011 returns the output register as the data byte. Command 010 returns the captured pins.
- R10: Command 100 sets the drive flag and command 101 clears it. `pin_oe` is all zero while the flag is clear. Codes 110 and 111 change nothing.
- R11: In echo framing the top command bit (frame bit 12) is ignored, so the effective command is {0, frame[11:10]}.
- R12: With `echo_mode`=1 and `od_nch`=1 the port is N-channel style: `pin_out`=0 and `pin_oe` set where the latch bit is 0. In every other case it is P-channel style: `pin_out`=1 and `pin_oe` set where the latch bit is 1.
- R13: While `rst_n` is low, `ser_do_oe` and `pin_oe` are zero. Reset clears the output register, the port latch and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| echo_mode | input | 1 | 1 selects echo framing, 0 normal framing |
| od_nch | input | 1 | Selects N-channel port style (echo framing only) |
| addr_strap | input | 4 | Device address straps |
| ser_en | input | 1 | Frame strobe, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_di | input | 1 | Serial data from the host |
| ser_do | output | 1 | Serial data to the host |
| ser_do_oe | output | 1 | Drive enable for `ser_do` (0 = high impedance) |
| pin_in | input | 8 | Levels seen on the port pins |
| pin_out | output | 8 | Level each port pin drives when enabled |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
The assertions assume that the straps, `echo_mode` and `od_nch` are static while a frame is open. They also assume that every serial clock phase lasts several system clocks, so that every edge is seen after synchronization and a frame's last rising clock edge comes well before the strobe rises. The stimulus keeps each serial half period at eight system clocks and changes the mode and strap inputs only between frames. It injects data glitches only one system clock wide and two clocks before a rising edge, so that exactly one vote sample sees the glitch.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int DATA_W      = 8;
  localparam int FRAME_W     = 2 * DATA_W;
  localparam int ADDR_NORMAL = 4;
  localparam int ADDR_ECHO   = 3;
  localparam int SR_W        = FRAME_W - ADDR_NORMAL;
  localparam int CNT_W       = $clog2(FRAME_W + 2);

  localparam logic [2:0] CMD_WRITE   = 3'b000;
  localparam logic [2:0] CMD_DRIVE   = 3'b001;
  localparam logic [2:0] CMD_RD_PINS = 3'b010;
  localparam logic [2:0] CMD_RD_REG  = 3'b011;
  localparam logic [2:0] CMD_SET_OE  = 3'b100;
  localparam logic [2:0] CMD_CLR_OE  = 3'b101;

  localparam logic ACK_LEVEL = 1'b0;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Address compare on the shift contents just after the last address bit.
  function automatic logic addr_ok(input logic echo, input logic [SR_W-1:0] s,
                                   input logic [ADDR_NORMAL-1:0] strap);
    if (echo) return s[ADDR_ECHO-1:0] == strap[ADDR_ECHO-1:0];
    return s[ADDR_NORMAL-1:0] == strap;
  endfunction

  // Command field; lsb is where the normal-mode field sits in the shifter.
  // Echo mode forces the top command bit to zero.
  function automatic logic [2:0] cmd_at(input logic echo, input logic [SR_W-1:0] s,
                                        input int lsb);
    if (echo) return {1'b0, s[lsb+1 +: 2]};
    return s[lsb +: 3];
  endfunction

  // Echo-back tap: after c rises, address bits sit at s[2], command bits at s[1].
  function automatic logic echo_tap(input logic [CNT_W-1:0] c, input logic [SR_W-1:0] s);
    if (c <= CNT_W'(ADDR_ECHO + 2)) return s[ADDR_ECHO-1];
    return s[1];
  endfunction

  function automatic logic data_tap(input logic [DATA_W-1:0] b, input logic [CNT_W-1:0] c);
    int idx;
    idx = FRAME_W - 1 - int'(c);
    return b[idx];
  endfunction
endpackage

// File: rtl/ioexp_sync.sv
module ioexp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ioexp_front.sv
module ioexp_front
  import ioexp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_raw,
  input  logic sclk_raw,
  input  logic di_raw,
  output logic busy,
  output logic en_fall,
  output logic en_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic di_vote
);
  logic [2:0] s_q;
  logic       en_p, sclk_p;
  logic [1:0] di_h;

  ioexp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({en_raw, sclk_raw, di_raw}), .q(s_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p   <= 1'b1;
      sclk_p <= 1'b0;
      di_h   <= '0;
    end else begin
      en_p   <= s_q[2];
      sclk_p <= s_q[1];
      di_h   <= {di_h[0], s_q[0]};
    end
  end

  assign busy      = ~s_q[2];
  assign en_fall   = en_p & ~s_q[2];
  assign en_rise   = ~en_p & s_q[2];
  assign sclk_rise = s_q[1] & ~sclk_p;
  assign sclk_fall = ~s_q[1] & sclk_p;
  assign di_vote   = maj3(s_q[0], di_h[0], di_h[1]);
endmodule

// File: rtl/ioexp_port.sv
module ioexp_port #(
  parameter int W = 8
) (
  input  logic [W-1:0] latch,
  input  logic         drive_en,
  input  logic         nch,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // N-channel pulls low on a 0; P-channel pushes high on a 1.
    assign pin_out[i] = ~nch;
    assign pin_oe[i]  = drive_en & (nch ? ~latch[i] : latch[i]);
  end
endmodule

// File: rtl/ioexp_slave.sv
module ioexp_slave
  import ioexp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              echo_mode,
  input  logic              od_nch,
  input  logic [3:0]        addr_strap,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_di,
  output logic              ser_do,
  output logic              ser_do_oe,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_W);

  logic busy, en_fall, en_rise, sclk_rise, sclk_fall, di_vote;

  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  cnt;
  logic              match_q;
  logic [DATA_W-1:0] tx_byte, out_reg, port_q;
  logic              flag_q, do_q, do_oe_q;

  // Named internal events for the checker.
  logic [SR_W-1:0]   sr_next;
  logic [CNT_W-1:0]  addr_len;
  logic              cmd_fire, do_step;
  logic [2:0]        run_cmd, early_cmd;
  logic [DATA_W-1:0] data_src;
  logic              do_next;

  ioexp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .en_raw(ser_en), .sclk_raw(ser_clk), .di_raw(ser_di),
    .busy(busy), .en_fall(en_fall), .en_rise(en_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .di_vote(di_vote)
  );

  assign sr_next   = {sr[SR_W-2:0], di_vote};
  assign addr_len  = echo_mode ? CNT_W'(ADDR_ECHO) : CNT_W'(ADDR_NORMAL);
  assign run_cmd   = cmd_at(echo_mode, sr, 9);
  assign early_cmd = cmd_at(echo_mode, sr, 1);
  assign cmd_fire  = en_rise && (cnt == CNT_FULL) && match_q;
  assign do_step   = busy && !en_fall && sclk_fall && match_q &&
                     (cnt >= addr_len) && (cnt < CNT_FULL);
  assign data_src  = (cnt == CNT_DATA && early_cmd == CMD_RD_REG) ? out_reg : tx_byte;
  assign do_next   = (cnt < CNT_DATA) ? (echo_mode ? echo_tap(cnt, sr) : ACK_LEVEL)
                                      : data_tap(data_src, cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      match_q <= 1'b0;
      tx_byte <= '0;
      out_reg <= '0;
      port_q  <= '0;
      flag_q  <= 1'b0;
      do_q    <= 1'b0;
      do_oe_q <= 1'b0;
    end else if (en_fall) begin
      cnt     <= '0;
      match_q <= 1'b0;
      do_oe_q <= 1'b0;
      tx_byte <= pin_in;
    end else if (en_rise) begin
      cnt     <= '0;
      match_q <= 1'b0;
      do_oe_q <= 1'b0;
      if (cmd_fire) begin
        case (run_cmd)
          CMD_WRITE:  out_reg <= sr[DATA_W-1:0];
          CMD_DRIVE:  port_q  <= out_reg;
          CMD_SET_OE: flag_q  <= 1'b1;
          CMD_CLR_OE: flag_q  <= 1'b0;
          default: ;
        endcase
      end
    end else if (busy && sclk_rise) begin
      sr <= sr_next;
      if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
      if (cnt + CNT_W'(1) == addr_len) match_q <= addr_ok(echo_mode, sr_next, addr_strap);
    end else if (do_step) begin
      do_oe_q <= 1'b1;
      do_q    <= do_next;
      if (cnt == CNT_DATA) tx_byte <= data_src;
    end
  end

  assign ser_do    = do_q;
  assign ser_do_oe = do_oe_q;

  ioexp_port #(.W(DATA_W)) u_port (
    .latch(port_q), .drive_en(flag_q), .nch(echo_mode & od_nch),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/ioexp_slave_chk.sv
module ioexp_slave_chk
  import ioexp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              echo_mode,
  input logic              ser_do,
  input logic              ser_do_oe,
  input logic              sclk_fall,
  input logic              en_rise,
  input logic              match_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] out_reg,
  input logic              flag_q,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_oe
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_QUIET_IN_RESET: assert (!ser_do_oe && pin_oe == '0) else $error("outputs driven in reset"); // R13
    end
  end

  AST_OE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_do_oe |-> match_q) else $error("DO driven without address match"); // R3

  AST_OE_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_do_oe) |-> $past(sclk_fall)) else $error("DO enabled away from clock fall"); // R4

  AST_DO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_do_oe && $past(ser_do_oe) && ser_do != $past(ser_do)) |-> $past(sclk_fall))
    else $error("DO changed away from clock fall"); // R4

  AST_DO_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !ser_do_oe) else $error("DO still driven after frame end"); // R7

  AST_REG_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_reg) |-> ($past(en_rise) && $past(cnt) == CNT_W'(FRAME_W) && $past(match_q)))
    else $error("register changed outside a full matched frame"); // R7

  AST_PORT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_oe) |-> flag_q) else $error("port driven with flag clear"); // R10

  AST_PCH_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_mode |-> (&pin_out)) else $error("N-channel style in normal framing"); // R12
endmodule

bind ioexp_slave ioexp_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .echo_mode(echo_mode), .ser_do(ser_do), .ser_do_oe(ser_do_oe),
  .sclk_fall(sclk_fall), .en_rise(en_rise), .match_q(match_q), .cnt(cnt),
  .out_reg(out_reg), .flag_q(flag_q), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/ioexp_slave_test.sv
module ioexp_slave_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       echo_mode = 1'b0;
  logic       od_nch = 1'b0;
  logic [3:0] addr_strap = 4'hA;
  logic       ser_en = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_di = 1'b0;
  logic       ser_do, ser_do_oe;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the block's visible state
  logic [7:0] m_reg = 8'h00;
  logic [7:0] m_port = 8'h00;
  logic       m_flag = 1'b0;

  ioexp_slave uut (
    .clk(clk), .rst_n(rst_n), .echo_mode(echo_mode), .od_nch(od_nch),
    .addr_strap(addr_strap), .ser_en(ser_en), .ser_clk(ser_clk), .ser_di(ser_di),
    .ser_do(ser_do), .ser_do_oe(ser_do_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mkf(input logic echo, input logic [3:0] a,
                                      input logic [2:0] c, input logic [7:0] d,
                                      input logic [1:0] spare);
    if (echo) return {a[2:0], c, spare, d};
    return {a, c, spare[0], d};
  endfunction

  function automatic logic hit_of(input logic echo, input logic [15:0] f);
    return echo ? (f[15:13] == addr_strap[2:0]) : (f[15:12] == addr_strap);
  endfunction

  function automatic logic [2:0] cmd_of(input logic echo, input logic [15:0] f);
    return echo ? {1'b0, f[11:10]} : f[11:9];
  endfunction

  // {oe, level} the host should see just before rising edge c+1
  function automatic logic [1:0] exp_do(input logic echo, input logic hit, input int c,
                                        input logic [15:0] f, input logic [7:0] d);
    if (!hit) return 2'b00;
    if (c >= 8) return {1'b1, d[15-c]};
    if (echo) begin
      case (c)
        3: return {1'b1, f[15]};
        4: return {1'b1, f[14]};
        5: return {1'b1, f[13]};
        6: return {1'b1, f[11]};
        7: return {1'b1, f[10]};
        default: return 2'b00;
      endcase
    end
    if (c >= 4) return 2'b10;
    return 2'b00;
  endfunction

  task automatic frame(input logic [15:0] f, input int nclk, input bit glitch, input string req);
    logic [15:0] dov = '0;
    logic [15:0] doe = '0;
    logic        hit;
    logic [7:0]  d;
    logic [2:0]  c;
    int          bad = 0;
    logic [1:0]  e;
    hit = hit_of(echo_mode, f);
    c   = cmd_of(echo_mode, f);
    d   = (c == 3'b011) ? m_reg : pin_in;
    @(negedge clk);
    ser_en = 1'b0;
    wait_sys(8);
    for (int i = 0; i < nclk; i++) begin
      ser_clk = 1'b0;
      ser_di  = (i < 16) ? f[15-i] : 1'b0;
      if (glitch) begin
        wait_sys(6);
        ser_di = ~ser_di;
        wait_sys(1);
        ser_di = ~ser_di;
        wait_sys(1);
      end else begin
        wait_sys(8);
      end
      if (i < 16) begin
        dov[i] = ser_do;
        doe[i] = ser_do_oe;
      end
      ser_clk = 1'b1;
      wait_sys(8);
    end
    ser_clk = 1'b0;
    wait_sys(8);
    ser_en = 1'b1;
    wait_sys(12);
    for (int i = 0; i < nclk && i < 16; i++) begin
      e = exp_do(echo_mode, hit, i, f, d);
      if (doe[i] !== e[1] || (e[1] && dov[i] !== e[0])) begin
        bad++;
        if (bad == 1)
          check(0, req, $sformatf("DO bit %0d frame %h", i, f), {30'd0, doe[i], dov[i]}, {30'd0, e});
      end
    end
    if (bad == 0) check(1, req, "DO sequence", 0, 0);
    check(ser_do_oe == 1'b0, "R7", "DO released after frame", {31'd0, ser_do_oe}, 0);
    if (hit && nclk == 16) begin
      case (c)
        3'b000: m_reg = f[7:0];
        3'b001: m_port = m_reg;
        3'b100: m_flag = 1'b1;
        3'b101: m_flag = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic port_check(input string req);
    logic       nch;
    logic [7:0] eoe, eout;
    nch  = echo_mode & od_nch;
    eoe  = m_flag ? (nch ? ~m_port : m_port) : 8'h00;
    eout = nch ? 8'h00 : 8'hFF;
    check(pin_oe == eoe, req, "pin_oe", {24'd0, pin_oe}, {24'd0, eoe});
    check(pin_out == eout, req, "pin_out", {24'd0, pin_out}, {24'd0, eout});
  endtask

  task automatic read_reg_check(input string req);
    // read-back returns m_reg in the data bits (R9); frame task compares it
    frame(mkf(echo_mode, addr_strap, 3'b011, 8'h00, 2'b00), 16, 0, req);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    wait_sys(5);
    check(ser_do_oe == 1'b0 && pin_oe == 8'h00, "R13", "outputs in reset",
          {23'd0, ser_do_oe, pin_oe}, 0);
    rst_n = 1'b1;
    wait_sys(5);
    port_check("R13");

    // normal framing, strap A
    frame(mkf(0, 4'hA, 3'b000, 8'h5A, 2'b00), 16, 0, "R5");  // write
    port_check("R8");
    pin_in = 8'hC3;
    read_reg_check("R9");                                     // read register
    frame(mkf(0, 4'hA, 3'b010, 8'h00, 2'b01), 16, 0, "R1");  // read pins
    frame(mkf(0, 4'hA, 3'b001, 8'h00, 2'b00), 16, 0, "R8");  // drive
    port_check("R8");
    frame(mkf(0, 4'hA, 3'b100, 8'h00, 2'b00), 16, 0, "R10"); // flag on
    port_check("R10");
    port_check("R12");

    // short and long frames change nothing
    frame(mkf(0, 4'hA, 3'b000, 8'hFF, 2'b00), 15, 0, "R7");
    frame(mkf(0, 4'hA, 3'b000, 8'hEE, 2'b00), 17, 0, "R7");
    read_reg_check("R7");

    // address mismatch: no drive, no effect
    frame(mkf(0, 4'h5, 3'b000, 8'h11, 2'b00), 16, 0, "R3");
    read_reg_check("R3");

    // unused codes change nothing
    frame(mkf(0, 4'hA, 3'b110, 8'h00, 2'b00), 16, 0, "R10");
    frame(mkf(0, 4'hA, 3'b111, 8'h00, 2'b00), 16, 0, "R10");
    port_check("R10");

    // glitched data bits still decoded
    frame(mkf(0, 4'hA, 3'b000, 8'h96, 2'b00), 16, 1, "R2");
    read_reg_check("R2");

    // echo framing, strap low bits 010; top command bit set but ignored
    echo_mode = 1'b1;
    frame(mkf(1, 4'h2, 3'b100, 8'h3C, 2'b11), 16, 0, "R11"); // acts as write
    read_reg_check("R11");
    frame(mkf(1, 4'h2, 3'b001, 8'h00, 2'b10), 16, 0, "R6");  // drive
    od_nch = 1'b1;
    wait_sys(2);
    port_check("R12");
    od_nch = 1'b0;
    wait_sys(2);
    port_check("R12");
    frame(mkf(1, 4'h6, 3'b000, 8'h77, 2'b00), 16, 0, "R3");  // mismatch
    read_reg_check("R3");
    frame(mkf(1, 4'h2, 3'b101, 8'h00, 2'b00), 16, 0, "R10"); // flag off
    port_check("R10");

    // random frames
    for (int n = 0; n < 60; n++) begin
      logic [3:0]  a;
      logic [15:0] f;
      int          nc;
      echo_mode  = 1'($urandom);
      od_nch     = 1'($urandom);
      if (($urandom % 8) == 0) addr_strap = 4'($urandom);
      pin_in     = 8'($urandom);
      a          = (($urandom % 4) != 0) ? addr_strap : 4'($urandom);
      nc         = (($urandom % 8) == 0) ? 15 + 2 * int'($urandom % 2) : 16;
      f          = mkf(echo_mode, a, 3'($urandom), 8'($urandom), 2'($urandom));
      frame(f, nc, 1'($urandom), echo_mode ? "R6" : "R5");
      port_check("R12");
    end
    finish_run();
  end
endmodule